// File: doc/BRIEF.md
# Execute-Stage Shift Unit with Double-Word Left Funnel

This block is the shifting part of a processor execute stage. It offers three operations on 32-bit words. The arithmetic right shift fills from the sign. The logical left shift fills with zeros. The funnel left shift joins a high word and a low word into one double word, shifts it left and keeps the top word. The shift result is combinational, so it appears on `result` in the same cycle the operands are presented.

A small condition-flag register sits beside the datapath. When an operation is issued, it captures the carry, overflow, sign and zero flags on the next rising clock edge. The shift distance comes from one of two places, chosen by `src_imm`: the low bits of the `amt_reg` operand, or the zero-extended `imm` field.

Opcode encoding on `op`: 0 = arithmetic right shift, 1 = logical left shift, 2 = funnel left shift, 3 = reserved (no operation).

Top module: `shift_unit`

## Requirements
- R1: With `op`=0, `result` is `data_lo` shifted right by the amount, and every vacated high bit equals `data_lo[31]`.
- R2: With `op`=1, `result` is `data_lo` shifted left by the amount, and every vacated low bit is 0.
- R3: With `op`=2, `result` is bits 63..32 of the 64-bit value {`data_hi`,`data_lo`} shifted left by the amount.
- R4: With `src_imm`=0 the amount is `amt_reg[4:0]`, and bits 31..5 of `amt_reg` have no effect. With `src_imm`=1 the amount is `imm` zero-extended.
- R5: An amount of 0 returns `data_lo` unchanged for `op` 0 and 1, and `data_hi` unchanged for `op` 2. In that case `flag_cy` is loaded with 0.
- R6: After an issued shift by n>0, `flag_cy` holds the last bit shifted out. That bit is `data_lo[n-1]` for `op` 0, `data_lo[32-n]` for `op` 1 and `data_hi[32-n]` for `op` 2.
- R7: Every issued shift loads `flag_ov` with 0.
- R8: After an issued shift, `flag_s` equals bit 31 of the result, and `flag_z` is 1 exactly when the result was all zeros.
- R9: The flags keep their value on a clock edge where `valid`=0 or `op`=3. With `op`=3, `result` is 0.
- R10: While `rst_n` is low, all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low synchronous reset of the flags |
| valid | input | 1 | An operation is issued this cycle |
| op | input | 2 | Operation select (encoding above) |
| src_imm | input | 1 | 1 = amount from `imm`, 0 = from `amt_reg` |
| amt_reg | input | 32 | Register operand supplying the amount |
| imm | input | 5 | Immediate amount |
| data_lo | input | 32 | Shifted operand, low word of the funnel |
| data_hi | input | 32 | High word of the funnel |
| result | output | 32 | Shift result (combinational) |
| flag_cy | output | 1 | Registered carry: last bit shifted out |
| flag_ov | output | 1 | Registered overflow, always cleared by a shift |
| flag_s | output | 1 | Registered sign of the result |
| flag_z | output | 1 | Registered zero indicator |

## Verification
The bench runs every amount from 0 to 31, through both amount sources, against eight operand patterns for each of the three shifts. It uses garbage in the upper bits of `amt_reg`, so a design that decoded too many amount bits would shift by the wrong distance. Amount 0 catches a carry taken from an out-of-range bit and a funnel that returns the low word instead of the high one. Amount 31 and negative patterns catch an arithmetic shift that fills with zeros. The last checks issue bubbles and the reserved opcode after a shift that set the flags, so a flag register that loaded on every edge would show changed flags.

// File: rtl/shu_pkg.sv
package shu_pkg;
    typedef enum logic [1:0] {
        OP_SAR  = 2'd0,
        OP_SHL  = 2'd1,
        OP_FSHL = 2'd2,
        OP_NOP  = 2'd3
    } shu_op_e;

    typedef struct packed {
        logic cy;
        logic ov;
        logic s;
        logic z;
    } shu_flags_t;
endpackage

// File: rtl/shu_amount_sel.sv
module shu_amount_sel #(
    parameter int XLEN = 32,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic            src_imm,
    input  logic [XLEN-1:0] amt_reg,
    input  logic [SHW-1:0]  imm,
    output logic [SHW-1:0]  amt
);
    // Only the low SHW bits of the register steer the shifter.
    logic unused_amt_hi;
    assign unused_amt_hi = ^amt_reg[XLEN-1:SHW];

    always_comb begin
        if (src_imm) amt = imm;
        else         amt = amt_reg[SHW-1:0];
    end
endmodule

// File: rtl/shu_shifter.sv
module shu_shifter
    import shu_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int SHW = $clog2(XLEN)
) (
    input  shu_op_e         op,
    input  logic [XLEN-1:0] lo_word,
    input  logic [XLEN-1:0] hi_word,
    input  logic [SHW-1:0]  amt,
    output logic [XLEN-1:0] res,
    output logic            cy
);
    // Each shifter carries one guard bit to catch the last bit out.
    logic signed [XLEN:0] sar_in;
    logic signed [XLEN:0] sar_out;
    logic        [XLEN:0] shl_out;
    logic        [XLEN:0] fun_top;
    logic [XLEN-1:0]      unused_fun_low;

    always_comb begin
        sar_in  = {lo_word, 1'b0};
        sar_out = sar_in >>> amt;
        shl_out = {1'b0, lo_word} << amt;
    end

    assign {fun_top, unused_fun_low} = {1'b0, hi_word, lo_word} << amt;

    always_comb begin
        unique case (op)
            OP_SAR: begin
                res = sar_out[XLEN:1];
                cy  = sar_out[0];
            end
            OP_SHL: begin
                res = shl_out[XLEN-1:0];
                cy  = shl_out[XLEN];
            end
            OP_FSHL: begin
                res = fun_top[XLEN-1:0];
                cy  = fun_top[XLEN];
            end
            default: begin
                res = '0;
                cy  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/shu_flag_reg.sv
module shu_flag_reg
    import shu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [XLEN-1:0] res,
    input  logic            cy,
    output shu_flags_t      flags
);
    shu_flags_t flags_nxt;

    always_comb begin
        flags_nxt.cy = cy;
        flags_nxt.ov = 1'b0;
        flags_nxt.s  = res[XLEN-1];
        flags_nxt.z  = ~|res;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    flags <= '0;
        else if (load) flags <= flags_nxt;
    end
endmodule

// File: rtl/shift_unit.sv
module shift_unit
    import shu_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid,
    input  logic [1:0]      op,
    input  logic            src_imm,
    input  logic [XLEN-1:0] amt_reg,
    input  logic [SHW-1:0]  imm,
    input  logic [XLEN-1:0] data_lo,
    input  logic [XLEN-1:0] data_hi,
    output logic [XLEN-1:0] result,
    output logic            flag_cy,
    output logic            flag_ov,
    output logic            flag_s,
    output logic            flag_z
);
    shu_op_e    op_e;
    logic [SHW-1:0] amt;
    logic       carry;
    logic       shift_go;
    shu_flags_t flags;

    assign op_e     = shu_op_e'(op);
    assign shift_go = valid && (op_e != OP_NOP);

    shu_amount_sel #(.XLEN(XLEN)) u_amt (
        .src_imm (src_imm),
        .amt_reg (amt_reg),
        .imm     (imm),
        .amt     (amt)
    );

    shu_shifter #(.XLEN(XLEN)) u_shift (
        .op      (op_e),
        .lo_word (data_lo),
        .hi_word (data_hi),
        .amt     (amt),
        .res     (result),
        .cy      (carry)
    );

    shu_flag_reg #(.XLEN(XLEN)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (shift_go),
        .res   (result),
        .cy    (carry),
        .flags (flags)
    );

    assign flag_cy = flags.cy;
    assign flag_ov = flags.ov;
    assign flag_s  = flags.s;
    assign flag_z  = flags.z;

    assert_ov_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        shift_go |=> !flag_ov);
    assert_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
        shift_go |=> flag_s == $past(result[XLEN-1]));
    assert_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        shift_go |=> flag_z == ($past(result) == '0));
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_go |=> $stable({flag_cy, flag_ov, flag_s, flag_z}));
    assert_zero_amt_cy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_go && amt == '0) |=> !flag_cy);
    assert_nop_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_NOP) |-> result == '0);
endmodule

// File: tb/shift_unit_test.sv
module shift_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [1:0]  op = 2'd0;
    logic        src_imm = 1'b0;
    logic [31:0] amt_reg = '0;
    logic [4:0]  imm = '0;
    logic [31:0] data_lo = '0;
    logic [31:0] data_hi = '0;
    logic [31:0] result;
    logic        flag_cy, flag_ov, flag_s, flag_z;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    shift_unit uut (
        .clk(clk), .rst_n(rst_n), .valid(valid), .op(op), .src_imm(src_imm),
        .amt_reg(amt_reg), .imm(imm), .data_lo(data_lo), .data_hi(data_hi),
        .result(result), .flag_cy(flag_cy), .flag_ov(flag_ov),
        .flag_s(flag_s), .flag_z(flag_z)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pattern(input int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'hFFFF_FFFF;
            2: return 32'h8000_0001;
            3: return 32'h7FFF_FFFE;
            4: return 32'hA5C3_1E69;
            5: return 32'h0000_0001;
            6: return 32'h8000_0000;
            default: return 32'h3C96_F00D;
        endcase
    endfunction

    task automatic run_op(input int o, input int n, input bit use_imm,
                          input logic [31:0] lo, input logic [31:0] hi);
        logic [31:0] exp_res;
        logic        exp_cy;
        logic [63:0] dw;
        string       tag;
        @(negedge clk);
        valid   = 1'b1;
        op      = 2'(o);
        src_imm = use_imm;
        imm     = use_imm ? 5'(n) : 5'(31 - n);
        amt_reg = use_imm ? 32'(n ^ 7) : {27'h5A5_A5A5 ^ 27'(lo), 5'(n)};
        data_lo = lo;
        data_hi = hi;
        if (o == 0) begin
            exp_res = 32'($signed(lo) >>> n);
            exp_cy  = (n == 0) ? 1'b0 : lo[n-1];
            tag = "R1";
        end else if (o == 1) begin
            exp_res = lo << n;
            exp_cy  = (n == 0) ? 1'b0 : lo[32-n];
            tag = "R2";
        end else begin
            dw      = {hi, lo} << n;
            exp_res = dw[63:32];
            exp_cy  = (n == 0) ? 1'b0 : hi[32-n];
            tag = "R3";
        end
        #2;
        if (n == 0) check("R5 zero amount result", result, (o == 2) ? hi : lo);
        else check(use_imm ? {tag, " R4 imm amount"} : {tag, " R4 reg amount"}, result, exp_res);
        @(posedge clk);
        #2;
        check("R6 carry", {31'd0, flag_cy}, {31'd0, exp_cy});
        check("R7 overflow cleared", {31'd0, flag_ov}, 32'd0);
        check("R8 sign", {31'd0, flag_s}, {31'd0, exp_res[31]});
        check("R8 zero", {31'd0, flag_z}, {31'd0, exp_res == 32'd0});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R10 reset cy", {31'd0, flag_cy}, 32'd0);
        check("R10 reset ov", {31'd0, flag_ov}, 32'd0);
        check("R10 reset s", {31'd0, flag_s}, 32'd0);
        check("R10 reset z", {31'd0, flag_z}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int o = 0; o < 3; o++)
            for (int p = 0; p < 8; p++)
                for (int s = 0; s < 2; s++)
                    for (int n = 0; n < 32; n++)
                        run_op(o, n, s[0], pattern(p), pattern(7 - p));

        // Set cy=1, s=1, z=0, then try to disturb the flags.
        run_op(0, 1, 1'b1, 32'h8000_0001, 32'h0);
        @(negedge clk);
        valid = 1'b0; op = 2'd1; data_lo = 32'h0; imm = 5'd0; src_imm = 1'b1;
        @(posedge clk); #2;
        check("R9 bubble holds cy", {31'd0, flag_cy}, 32'd1);
        check("R9 bubble holds s", {31'd0, flag_s}, 32'd1);
        check("R9 bubble holds z", {31'd0, flag_z}, 32'd0);
        @(negedge clk);
        valid = 1'b1; op = 2'd3; data_lo = 32'h0; data_hi = 32'hFFFF_FFFF;
        #2;
        check("R9 reserved result", result, 32'd0);
        @(posedge clk); #2;
        check("R9 reserved holds cy", {31'd0, flag_cy}, 32'd1);
        check("R9 reserved holds s", {31'd0, flag_s}, 32'd1);
        check("R9 reserved holds z", {31'd0, flag_z}, 32'd0);
        @(negedge clk);
        valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #2;
        check("R10 reset clears cy", {31'd0, flag_cy}, 32'd0);
        check("R10 reset clears s", {31'd0, flag_s}, 32'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule